// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block moves outgoing frames from system memory to a byte stream. Software builds a circular list of 8-byte descriptors in memory. Each descriptor gives a buffer address, a buffer length and a few control flags. Software then points the block at the start of that list and pokes a "go" strobe. The engine walks the list one descriptor at a time. It fetches each buffer a 32-bit word at a time and sends the bytes out on a valid/ready stream. Several buffers can make up one frame, and the last byte of a frame carries an end marker.

When the engine has finished with a descriptor, it returns it to software. It does this by writing the first descriptor word back with the ownership bit cleared. It also raises one-cycle event pulses for the interrupt controller: one per buffer, one per completed frame, and one when a frame ran past the length cap and was cut short. The ring position survives between passes, so software can keep appending descriptors and poking the strobe.

Top module: `txd_ring_engine`

## Requirements
- R1: After synchronous reset, `mem_valid`, `tx_valid` and all three event outputs are low.
- R2: A `kick` pulse starts a pass only while `tx_enable` is high; with `tx_enable` low it causes no memory request and no output byte.
- R3: A descriptor at address A holds a 32-bit word at A with flags in bits 31:16 and byte length in bits 15:0, and the buffer address in the word at A+4. Flag bit 15 means ready (owned by the engine), bit 13 means wrap, bit 11 means end of frame. All memory requests are word aligned and stay stable until `mem_ready`.
- R4: Buffer bytes are sent in address order starting at the buffer address, with the most significant byte of each memory word holding the lowest address. Any byte offset is accepted.
- R5: The bytes of consecutive buffers are joined into one frame. `tx_last` is high only on the final byte of the buffer whose end-of-frame flag is set.
- R6: For every descriptor handled, the word at A is written back with bit 15 cleared and all other bits unchanged. After that write is accepted, `ev_buf_done` pulses for one cycle, and `ev_frame_done` pulses in the same cycle when the end-of-frame flag is set.
- R7: A pass ends at the first descriptor whose ready bit is clear. That descriptor is not written back, and the next pass starts at the same descriptor.
- R8: After a descriptor with the wrap flag, the next descriptor is read at the ring base. Otherwise it is read at A+8.
- R9: A frame never exceeds MAX_FRAME (default 2032) bytes. A buffer that would cross the cap is shortened to fit, and `ev_babble` pulses together with that descriptor's `ev_buf_done`.
- R10: One pass handles at most MAX_DESC (default 1024) descriptors. Any further ready descriptors stay untouched until the next kick.
- R11: Writing the ring base clears its two low bits. While no pass runs, the write also moves the current descriptor position to the new base.
- R12: A zero-length buffer that carries the end-of-frame flag still ends the frame: the marker lands on the final byte of the preceding buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable from the control register |
| kick | input | 1 | One-cycle "descriptors available" strobe |
| ring_base_we | input | 1 | Write strobe for the ring base register |
| ring_base_wdata | input | 32 | New ring base address |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| ev_buf_done | output | 1 | Pulse: one descriptor handed back |
| ev_frame_done | output | 1 | Pulse: one frame completed |
| ev_babble | output | 1 | Pulse: a buffer was cut at the frame cap |

## Verification
The bench targets several corner cases. Odd buffer byte offsets catch a wrong byte lane order, which would scramble or shift the data. A zero-length end-of-frame buffer checks that the frame is still closed rather than left without an end marker. A two-buffer frame that crosses the 2032-byte cap must produce exactly 2032 bytes and one babble pulse; a faulty design would overrun or drop bytes. A ring of more than 1024 ready descriptors checks that exactly 1024 are handed back in one pass. Further passes check where the ring resumes: after a stop on a non-ready descriptor, after a wrap, and after a base write with stray low bits. A design that got these wrong would re-read or skip descriptors.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int unsigned BIT_READY = 15;
    localparam int unsigned BIT_WRAP  = 13;
    localparam int unsigned BIT_EOF   = 11;
    localparam logic [15:0] OWN_CLEAR = 16'h7FFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PTR,
        ST_DATA,
        ST_FETCH,
        ST_FLUSH,
        ST_WB
    } txd_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } txd_hdr_t;

    // Most significant byte carries the lowest address.
    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
        logic [7:0] b;
        case (lane)
            2'd0:    b = w[31:24];
            2'd1:    b = w[23:16];
            2'd2:    b = w[15:8];
            default: b = w[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/txd_len_clamp.sv
module txd_len_clamp #(
    parameter int unsigned MAX_FRAME = 2032,
    parameter int unsigned FS_W      = 11
) (
    input  logic [FS_W-1:0] frame_bytes,
    input  logic [15:0]     req_len,
    output logic [15:0]     eff_len,
    output logic            cut
);
    logic [15:0] room;

    always_comb begin
        room    = 16'(MAX_FRAME) - 16'(frame_bytes);
        cut     = req_len > room;
        eff_len = cut ? room : req_len;
    end
endmodule

// File: rtl/txd_byte_out.sv
module txd_byte_out (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       flush_req,
    output logic       flush_done,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    input  logic       tx_ready
);
    logic       held_q;
    logic [7:0] byte_q;

    // A held byte leaves only once it is known whether another byte follows.
    assign tx_valid   = held_q && (in_valid || flush_req);
    assign tx_data    = byte_q;
    assign tx_last    = flush_req;
    assign in_ready   = !held_q || tx_ready;
    assign flush_done = flush_req && (!held_q || tx_ready);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            held_q <= 1'b0;
            byte_q <= 8'h00;
        end else if (in_valid && in_ready) begin
            held_q <= 1'b1;
            byte_q <= in_byte;
        end else if (flush_req && tx_ready) begin
            held_q <= 1'b0;
        end
    end

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_one_source_R12: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && flush_req));
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
    import txd_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned MAX_FRAME = 2032,
    parameter int unsigned MAX_DESC  = 1024
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_enable,
    input  logic          kick,
    input  logic          ring_base_we,
    input  logic [AW-1:0] ring_base_wdata,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ready,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          ev_buf_done,
    output logic          ev_frame_done,
    output logic          ev_babble
);
    localparam int unsigned FS_W = $clog2(MAX_FRAME + 1);
    localparam int unsigned DC_W = $clog2(MAX_DESC + 1);

    txd_state_e      state_q;
    logic [AW-1:0]   base_q, cur_q, baddr_q;
    txd_hdr_t        hdr_q;
    logic [15:0]     rem_q;
    logic [31:0]     word_q;
    logic            word_ok_q;
    logic [FS_W-1:0] fsize_q;
    logic [DC_W-1:0] dcnt_q;
    logic            cut_q;

    logic        start;
    logic [15:0] eff_len;
    logic        eff_cut;
    logic        in_valid, in_ready, flush_req, flush_done;
    logic [7:0]  in_byte;

    assign start = (state_q == ST_IDLE) && kick && tx_enable;

    txd_len_clamp #(.MAX_FRAME(MAX_FRAME), .FS_W(FS_W)) u_clamp (
        .frame_bytes (fsize_q),
        .req_len     (hdr_q.len),
        .eff_len     (eff_len),
        .cut         (eff_cut)
    );

    assign in_valid  = (state_q == ST_DATA) && word_ok_q && (rem_q != 16'd0);
    assign in_byte   = lane_byte(word_q, baddr_q[1:0]);
    assign flush_req = (state_q == ST_FLUSH);

    txd_byte_out u_out (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_ready   (in_ready),
        .flush_req  (flush_req),
        .flush_done (flush_done),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready)
    );

    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = {hdr_q.flags & OWN_CLEAR, hdr_q.len};
        case (state_q)
            ST_HDR:   begin mem_valid = 1'b1; mem_addr = cur_q; end
            ST_PTR:   begin mem_valid = 1'b1; mem_addr = cur_q + AW'(4); end
            ST_FETCH: begin mem_valid = 1'b1; mem_addr = {baddr_q[AW-1:2], 2'b00}; end
            ST_WB:    begin mem_valid = 1'b1; mem_we = 1'b1; mem_addr = cur_q; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            base_q        <= '0;
            cur_q         <= '0;
            baddr_q       <= '0;
            hdr_q         <= '0;
            rem_q         <= '0;
            word_q        <= '0;
            word_ok_q     <= 1'b0;
            fsize_q       <= '0;
            dcnt_q        <= '0;
            cut_q         <= 1'b0;
            ev_buf_done   <= 1'b0;
            ev_frame_done <= 1'b0;
            ev_babble     <= 1'b0;
        end else begin
            ev_buf_done   <= 1'b0;
            ev_frame_done <= 1'b0;
            ev_babble     <= 1'b0;
            if (ring_base_we) begin
                base_q <= {ring_base_wdata[AW-1:2], 2'b00};
            end
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_HDR;
                        dcnt_q  <= '0;
                        fsize_q <= '0;
                    end else if (ring_base_we) begin
                        cur_q <= {ring_base_wdata[AW-1:2], 2'b00};
                    end
                end
                ST_HDR: begin
                    if (mem_ready) begin
                        if (!mem_rdata[16 + BIT_READY]) begin
                            state_q <= ST_IDLE;
                        end else begin
                            hdr_q   <= txd_hdr_t'(mem_rdata);
                            state_q <= ST_PTR;
                        end
                    end
                end
                ST_PTR: begin
                    if (mem_ready) begin
                        baddr_q   <= mem_rdata[AW-1:0];
                        rem_q     <= eff_len;
                        cut_q     <= eff_cut;
                        fsize_q   <= fsize_q + FS_W'(eff_len);
                        word_ok_q <= 1'b0;
                        state_q   <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (rem_q == 16'd0) begin
                        state_q <= hdr_q.flags[BIT_EOF] ? ST_FLUSH : ST_WB;
                    end else if (!word_ok_q) begin
                        state_q <= ST_FETCH;
                    end else if (in_ready) begin
                        baddr_q <= baddr_q + AW'(1);
                        rem_q   <= rem_q - 16'd1;
                        if (baddr_q[1:0] == 2'd3) begin
                            word_ok_q <= 1'b0;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ready) begin
                        word_q    <= mem_rdata;
                        word_ok_q <= 1'b1;
                        state_q   <= ST_DATA;
                    end
                end
                ST_FLUSH: begin
                    if (flush_done) begin
                        state_q <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (mem_ready) begin
                        ev_buf_done   <= 1'b1;
                        ev_frame_done <= hdr_q.flags[BIT_EOF];
                        ev_babble     <= cut_q;
                        if (hdr_q.flags[BIT_EOF]) begin
                            fsize_q <= '0;
                        end
                        cur_q   <= hdr_q.flags[BIT_WRAP] ? base_q : cur_q + AW'(8);
                        dcnt_q  <= dcnt_q + 1'b1;
                        state_q <= (dcnt_q + 1'b1 == DC_W'(MAX_DESC)) ? ST_IDLE : ST_HDR;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker: bytes accepted in the frame under way.
    logic [FS_W:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst || start) begin
            seen_q <= '0;
        end else if (tx_valid && tx_ready) begin
            seen_q <= tx_last ? '0 : seen_q + 1'b1;
        end
    end

    assert_frame_cap_R9: assert property (@(posedge clk) disable iff (rst)
        seen_q <= (FS_W+1)'(MAX_FRAME));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_aligned_R11: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_addr[1:0] == 2'b00);

    assert_event_after_wb_R6: assert property (@(posedge clk) disable iff (rst)
        ev_buf_done |-> $past(mem_valid && mem_we && mem_ready));

    assert_pass_limit_R10: assert property (@(posedge clk) disable iff (rst)
        dcnt_q <= DC_W'(MAX_DESC));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !mem_valid && !tx_valid);
endmodule

// File: tb/txd_ring_engine_bench.sv
module txd_ring_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_enable = 1'b0, kick = 1'b0, ring_base_we = 1'b0;
    logic [31:0] ring_base_wdata = '0;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        ev_buf_done, ev_frame_done, ev_babble;

    always #2 clk = ~clk;

    int unsigned cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;
    assign mem_ready = (cyc % 4) != 3;
    assign tx_ready  = (cyc % 8) != 5;

    logic [31:0] mem [0:16383];
    assign mem_rdata = mem[mem_addr[15:2]];
    always @(posedge clk) if (mem_valid && mem_ready && mem_we) mem[mem_addr[15:2]] <= mem_wdata;

    txd_ring_engine u_txd_ring_engine (.*);

    byte unsigned q_b[$];
    bit           q_l[$];
    int n_buf = 0, n_frm = 0, n_bab = 0, n_memv = 0;
    bit seen_first = 0;
    logic [31:0] first_addr = '0;
    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin q_b.push_back(tx_data); q_l.push_back(tx_last); end
        if (ev_buf_done) n_buf++;
        if (ev_frame_done) n_frm++;
        if (ev_babble) n_bab++;
        if (mem_valid) n_memv++;
        if (mem_valid && !seen_first) begin seen_first <= 1; first_addr <= mem_addr; end
    end

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic byte unsigned pat(input int unsigned a);
        return 8'((a & 8'hFF) ^ ((a >> 8) & 8'hFF) ^ 8'h5A);
    endfunction

    task automatic put_desc(input int unsigned a, input logic [15:0] f, input logic [15:0] l, input int unsigned b);
        mem[a >> 2]       = {f, l};
        mem[(a >> 2) + 1] = b;
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); ring_base_we = 1; ring_base_wdata = v;
        @(negedge clk); ring_base_we = 0;
    endtask

    task automatic run_pass();
        q_b.delete(); q_l.delete(); seen_first = 0;
        @(negedge clk); kick = 1;
        @(negedge clk); kick = 0;
        for (int q = 0; q < 24; ) begin
            @(negedge clk);
            if (mem_valid || tx_valid) q = 0; else q++;
        end
    endtask

    // Compare captured stream against concatenated segments.
    task automatic cmp_stream(input string tag, input int unsigned a0, input int n0,
                              input int unsigned a1, input int n1);
        int bad = -1;
        byte unsigned e;
        chk(q_b.size() == n0 + n1, {tag, " length"}, q_b.size(), n0 + n1);
        for (int i = 0; i < q_b.size() && i < n0 + n1; i++) begin
            e = (i < n0) ? pat(a0 + i) : pat(a1 + i - n0);
            if (bad < 0 && (q_b[i] !== e || q_l[i] !== (i == n0 + n1 - 1))) bad = i;
        end
        chk(bad < 0, {tag, " bytes/last"}, bad, -1);
    endtask

    // Table: {buffer length, byte offset}
    localparam logic [17:0] VEC [6] = '{
        {16'd1, 2'd0}, {16'd4, 2'd0}, {16'd5, 2'd3},
        {16'd7, 2'd2}, {16'd16, 2'd1}, {16'd9, 2'd0}};

    initial begin
        int b0, f0, a0;
        repeat (80000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int b0, f0, a0;
        for (int w = 0; w < 16384; w++)
            mem[w] = {pat(4*w), pat(4*w+1), pat(4*w+2), pat(4*w+3)};
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!tx_valid && !mem_valid, "R1 outputs idle", {tx_valid, mem_valid}, 0);
        chk(!ev_buf_done && !ev_frame_done && !ev_babble, "R1 events", ev_buf_done, 0);

        // R2: kick while disabled
        put_desc(32'h100, 16'hA800, 16'd4, 32'h2000);
        set_base(32'h100);
        n_memv = 0;
        run_pass();
        chk(n_memv == 0, "R2 no request when disabled", n_memv, 0);
        chk(q_b.size() == 0, "R2 no bytes when disabled", q_b.size(), 0);
        tx_enable = 1;

        // Table walk: single-buffer frames, wrap set, base with stray low bits (R11)
        for (int i = 0; i < 6; i++) begin
            int len, off;
            len = int'(VEC[i][17:2]); off = int'(VEC[i][1:0]);
            put_desc(32'h100, 16'hA800, 16'(len), 32'h2000 + off);
            set_base(32'h101 + (i % 3));
            b0 = n_buf; f0 = n_frm;
            run_pass();
            cmp_stream("R4 R5 vector", 32'h2000 + off, len, 0, 0);
            chk(n_buf - b0 == 1, "R6 buffer event", n_buf - b0, 1);
            chk(n_frm - f0 == 1, "R6 frame event", n_frm - f0, 1);
            chk(mem[32'h40] == {16'h2800, 16'(len)}, "R6 write-back", mem[32'h40], {16'h2800, 16'(len)});
            chk(first_addr == 32'h100, "R11 base alignment", first_addr, 32'h100);
        end

        // Multi-buffer frame, zero-length closing buffer, stop on non-ready
        put_desc(32'h200, 16'h8000, 16'd3, 32'h2101);
        put_desc(32'h208, 16'h8000, 16'd5, 32'h2200);
        put_desc(32'h210, 16'h8800, 16'd0, 32'h2300);
        put_desc(32'h218, 16'h0000, 16'd2, 32'h2400);
        set_base(32'h200);
        b0 = n_buf; f0 = n_frm;
        run_pass();
        cmp_stream("R5 R12 gather", 32'h2101, 3, 32'h2200, 5);
        chk(n_buf - b0 == 3, "R6 three buffers", n_buf - b0, 3);
        chk(n_frm - f0 == 1, "R12 frame closed", n_frm - f0, 1);
        chk(mem[32'h86] == {16'h0000, 16'd2}, "R7 non-ready untouched", mem[32'h86], {16'h0000, 16'd2});

        put_desc(32'h218, 16'hA800, 16'd2, 32'h2400);
        run_pass();
        chk(first_addr == 32'h218, "R7 resume position", first_addr, 32'h218);
        cmp_stream("R7 resumed frame", 32'h2400, 2, 0, 0);

        put_desc(32'h200, 16'h8800, 16'd1, 32'h2500);
        run_pass();
        chk(first_addr == 32'h200, "R8 wrap to base", first_addr, 32'h200);
        cmp_stream("R8 wrapped frame", 32'h2500, 1, 0, 0);

        // R9: cap at 2032 bytes
        put_desc(32'h300, 16'h8000, 16'd2000, 32'h3000);
        put_desc(32'h308, 16'hA800, 16'd100, 32'h4000);
        set_base(32'h300);
        a0 = n_bab; f0 = n_frm;
        run_pass();
        cmp_stream("R9 truncated frame", 32'h3000, 2000, 32'h4000, 32);
        chk(n_bab - a0 == 1, "R9 babble event", n_bab - a0, 1);
        chk(n_frm - f0 == 1, "R9 frame event", n_frm - f0, 1);
        chk(mem[32'hC2] == {16'h2800, 16'd100}, "R9 length kept", mem[32'hC2], {16'h2800, 16'd100});

        // R10: per-pass descriptor limit
        for (int d = 0; d < 1030; d++) put_desc(32'h8000 + 8*d, 16'h8000, 16'd0, 32'h0);
        set_base(32'h8000);
        b0 = n_buf;
        run_pass();
        chk(n_buf - b0 == 1024, "R10 descriptors per pass", n_buf - b0, 1024);
        chk(mem[(32'h8000 + 8*1023) >> 2][31:16] == 16'h0000, "R10 last handled", mem[(32'h8000 + 8*1023) >> 2], 0);
        chk(mem[(32'h8000 + 8*1024) >> 2][31:16] == 16'h8000, "R10 next untouched", mem[(32'h8000 + 8*1024) >> 2], 32'h80000000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule